// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Unit

The unit multiplies two operands over a small, fixed number of clock cycles and leaves the result in a 64-bit accumulator. The accumulator is held as a high and a low 32-bit register, and both halves are always visible on output ports. Four operations are offered. There are narrow and wide multiplies that overwrite the accumulator, and narrow and wide multiplies whose product is added into it. A single select picks two's-complement or unsigned interpretation of the operands.

A caller places an operation code, two operands and the signedness select on the inputs and pulses `start` for one cycle. `busy` stays high while the operation runs. `done` pulses for one cycle when the accumulator holds the new value. The accumulator can be zeroed through `clear` whenever the unit is idle.

The datapath holds one 32x16 multiplier. A wide product is built from two passes over the two halves of the second operand. An accumulate operation spends one more cycle on the 64-bit addition. This addition path is shared by both operand widths.

Top module: `seq_mac`

## Requirements
- R1: Operation code 0 is the narrow multiply. It multiplies bits 15:0 of each operand and ignores bits 31:16. It writes the 32-bit product to `acc_lo`, leaves `acc_hi` unchanged, and raises `done` 2 cycles after the `start` cycle.
- R2: Operation code 1 is the narrow accumulate. It extends the 32-bit narrow product to 64 bits, with sign or zero extension chosen by `sgn_mode`. It adds that value into {`acc_hi`,`acc_lo`} modulo 2^64 and raises `done` 3 cycles after `start`.
- R3: Operation code 2 is the wide multiply. It overwrites {`acc_hi`,`acc_lo`} with the 64-bit product of the full 32-bit operands and raises `done` 3 cycles after `start`.
- R4: Operation code 3 is the wide accumulate. It adds the 64-bit product of the full operands into {`acc_hi`,`acc_lo`} modulo 2^64 and raises `done` 4 cycles after `start`.
- R5: When `sgn_mode` is 1, operands are two's-complement numbers. When it is 0, they are unsigned. This applies at both widths and includes the most negative values.
- R6: `done` is high for exactly one cycle, and the accumulator holds the new value in that cycle. `busy` is high from the cycle after an accepted `start` up to the cycle before `done`. A `start` in the `done` cycle is accepted.
- R7: A `start` while `busy` is high is ignored. The running operation keeps its code, operands, result and latency.
- R8: `clear` while idle zeroes both accumulator halves from the next cycle. `clear` while `busy` is high has no effect.
- R9: After a synchronous active-low reset, `busy` and `done` are 0 and both accumulator halves are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; taken only while idle |
| op_code | input | 2 | 0 narrow multiply, 1 narrow accumulate, 2 wide multiply, 3 wide accumulate |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sgn_mode | input | 1 | 1 two's-complement operands, 0 unsigned |
| clear | input | 1 | Zero the accumulator while idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
The bench measures the latency of every operation code. A control path that misses or adds a pass shows a `done` on the wrong cycle. It drives the extreme operands: the most negative 32-bit value times itself, all-ones unsigned, and negative narrow values with garbage in bits 31:16. A wrong magnitude, a wrong sign fix-up or a missing narrow extension would show as a wrong accumulator value or as a corrupted `acc_hi`. It also drives a second `start` during a run and holds `clear` through a run. A unit that re-latched or obeyed either would change the result or the latency. A back-to-back `start` in the `done` cycle exposes a unit that drops that request or reads a stale accumulator.

// File: rtl/seq_mac_pkg.sv
// Package: shared operation codes and derived scheduling figures for the
// sequential multiply-accumulate unit. Assumes a two-pass wide multiply.
package seq_mac_pkg;

    typedef enum logic [1:0] {
        OP_MUL_N = 2'd0,
        OP_MAC_N = 2'd1,
        OP_MUL_W = 2'd2,
        OP_MAC_W = 2'd3
    } mac_op_e;

    // Wide operations take two multiplier passes, narrow ones take one.
    function automatic logic [1:0] op_passes(mac_op_e op);
        return op[1] ? 2'd2 : 2'd1;
    endfunction

    // Accumulating operations spend one extra cycle on the 64-bit add.
    function automatic logic op_accum(mac_op_e op);
        return op[0];
    endfunction

    // Cycles from the start cycle to the done cycle.
    function automatic logic [2:0] op_latency(mac_op_e op);
        return 3'(op_passes(op)) + 3'(op_accum(op)) + 3'd1;
    endfunction

endpackage

// File: rtl/seq_mac_ctrl.sv
// Module: seq_mac_ctrl
// Sequencer. It accepts a start only while idle and latches the operation
// code. It then walks the multiplier passes and, for accumulate codes, one
// add step. Assumes the datapath finishes one pass per cycle.
module seq_mac_ctrl
    import seq_mac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op_code,
    input  logic       clear,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       mult_en,
    output logic       pass_sel,
    output logic       pass_first,
    output logic       wr_prod,
    output logic       add_prod,
    output logic       wide,
    output logic       clear_ok
);

    logic    busy_q;
    logic    done_q;
    mac_op_e op_q;
    logic [1:0] step_q;
    logic [1:0] n_pass;
    logic       last_pass;
    logic       finish;

    // Purpose: decode the current step into datapath strobes.
    always_comb begin
        accept     = start && !busy_q;
        n_pass     = op_passes(op_q);
        wide       = op_q[1];
        mult_en    = busy_q && (step_q < n_pass);
        last_pass  = (step_q == n_pass - 2'd1);
        pass_sel   = step_q[0];
        pass_first = (step_q == 2'd0);
        wr_prod    = mult_en && last_pass && !op_accum(op_q);
        add_prod   = busy_q && op_accum(op_q) && (step_q == n_pass);
        finish     = wr_prod || add_prod;
        clear_ok   = clear && !busy_q;
    end

    // Purpose: hold the run state, the step counter and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            op_q   <= OP_MUL_N;
            step_q <= 2'd0;
        end else begin
            done_q <= finish;
            if (accept) begin
                busy_q <= 1'b1;
                op_q   <= mac_op_e'(op_code);
                step_q <= 2'd0;
            end else if (finish) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                step_q <= step_q + 2'd1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

endmodule

// File: rtl/seq_mac_datapath.sv
// Module: seq_mac_datapath
// Operand conditioning and the multiplier. It forms unsigned magnitudes and
// a result sign at start, then builds the product magnitude over one or two
// passes of a DW x DW/2 multiplier. It offers the signed result both as it
// forms (for overwrite) and as held (for accumulate). Assumes DW is even.
module seq_mac_datapath #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [1:0]      op_code,
    input  logic            sgn_mode,
    input  logic [DW-1:0]   opnd_a,
    input  logic [DW-1:0]   opnd_b,
    input  logic            mult_en,
    input  logic            pass_sel,
    input  logic            pass_first,
    output logic [2*DW-1:0] res_now,
    output logic [2*DW-1:0] res_held
);

    localparam int HW = DW / 2;
    localparam int AW = 2 * DW;
    localparam int PW = DW + HW;

    logic [DW-1:0] mag_a_q, mag_b_q;
    logic          neg_q;
    logic [AW-1:0] prod_q;
    logic [AW-1:0] prod_next;
    logic [PW-1:0] partial;
    logic [AW-1:0] shifted;
    logic [HW-1:0] b_slice;

    // Extend a narrow operand to DW bits according to the signedness select.
    function automatic logic [DW-1:0] widen(logic [DW-1:0] v, logic is_wide, logic sg);
        if (is_wide) return v;
        return sg ? {{HW{v[HW-1]}}, v[HW-1:0]} : {{HW{1'b0}}, v[HW-1:0]};
    endfunction

    // Absolute value of a widened operand, or the value itself when unsigned.
    function automatic logic [DW-1:0] magnitude(logic [DW-1:0] v, logic sg);
        return (sg && v[DW-1]) ? (~v + 1'b1) : v;
    endfunction

    logic [DW-1:0] ext_a, ext_b;

    // Purpose: widen both operands for the incoming operation.
    always_comb begin
        ext_a = widen(opnd_a, op_code[1], sgn_mode);
        ext_b = widen(opnd_b, op_code[1], sgn_mode);
    end

    // Purpose: latch magnitudes and result sign when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_a_q <= '0;
            mag_b_q <= '0;
            neg_q   <= 1'b0;
        end else if (accept) begin
            mag_a_q <= magnitude(ext_a, sgn_mode);
            mag_b_q <= magnitude(ext_b, sgn_mode);
            neg_q   <= sgn_mode && (ext_a[DW-1] ^ ext_b[DW-1]);
        end
    end

    // Purpose: one pass of the multiplier and the running partial sum.
    always_comb begin
        b_slice   = pass_sel ? mag_b_q[DW-1:HW] : mag_b_q[HW-1:0];
        partial   = {{HW{1'b0}}, mag_a_q} * {{DW{1'b0}}, b_slice};
        shifted   = pass_sel ? {partial, {HW{1'b0}}} : {{HW{1'b0}}, partial};
        prod_next = (pass_first ? '0 : prod_q) + shifted;
        res_now   = neg_q ? (~prod_next + 1'b1) : prod_next;
        res_held  = neg_q ? (~prod_q + 1'b1) : prod_q;
    end

    // Purpose: hold the product magnitude between passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (mult_en) begin
            prod_q <= prod_next;
        end
    end

endmodule

// File: rtl/seq_mac_acc.sv
// Module: seq_mac_acc
// The 64-bit accumulator as two DW-bit halves. It takes an overwrite (full or
// low half only), an add of the held product, or a clear. Assumes the
// sequencer never raises two of these strobes in one cycle.
module seq_mac_acc #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_ok,
    input  logic            wr_prod,
    input  logic            add_prod,
    input  logic            wide,
    input  logic [2*DW-1:0] res_now,
    input  logic [2*DW-1:0] res_held,
    output logic [DW-1:0]   acc_hi,
    output logic [DW-1:0]   acc_lo
);

    localparam int AW = 2 * DW;

    logic [DW-1:0] hi_q, lo_q;
    logic [AW-1:0] sum;

    // Purpose: the shared 64-bit add path for both operand widths.
    always_comb begin
        sum = {hi_q, lo_q} + res_held;
    end

    // Purpose: update the accumulator halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (clear_ok) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (add_prod) begin
            {hi_q, lo_q} <= sum;
        end else if (wr_prod) begin
            lo_q <= res_now[DW-1:0];
            if (wide) hi_q <= res_now[AW-1:DW];
        end
    end

    assign acc_hi = hi_q;
    assign acc_lo = lo_q;

endmodule

// File: rtl/seq_mac.sv
// Module: seq_mac (top)
// Sequential multiply-accumulate unit: sequencer, multiplier datapath and
// accumulator. Assumes inputs are synchronous to clk.
module seq_mac
    import seq_mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_code,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          sgn_mode,
    input  logic          clear,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo
);

    localparam int AW = 2 * DW;

    logic          accept, mult_en, pass_sel, pass_first;
    logic          wr_prod, add_prod, wide, clear_ok;
    logic [AW-1:0] res_now, res_held;

    seq_mac_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_code    (op_code),
        .clear      (clear),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .mult_en    (mult_en),
        .pass_sel   (pass_sel),
        .pass_first (pass_first),
        .wr_prod    (wr_prod),
        .add_prod   (add_prod),
        .wide       (wide),
        .clear_ok   (clear_ok)
    );

    seq_mac_datapath #(.DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .op_code    (op_code),
        .sgn_mode   (sgn_mode),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .mult_en    (mult_en),
        .pass_sel   (pass_sel),
        .pass_first (pass_first),
        .res_now    (res_now),
        .res_held   (res_held)
    );

    seq_mac_acc #(.DW(DW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_ok (clear_ok),
        .wr_prod  (wr_prod),
        .add_prod (add_prod),
        .wide     (wide),
        .res_now  (res_now),
        .res_held (res_held),
        .acc_hi   (acc_hi),
        .acc_lo   (acc_lo)
    );

endmodule

// File: rtl/seq_mac_chk.sv
// Module: seq_mac_chk
// Protocol checker bound to seq_mac. It tracks the accepted operation and the
// cycles since its start, and checks latency, pulse shape, clear and the
// narrow-multiply high half.
module seq_mac_chk
    import seq_mac_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    op_code,
    input logic          clear,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] acc_hi,
    input logic [DW-1:0] acc_lo
);

    mac_op_e    op_seen;
    logic [2:0] age;

    // Purpose: remember the accepted operation and count cycles since start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_seen <= OP_MUL_N;
            age     <= 3'd0;
        end else if (start && !busy) begin
            op_seen <= mac_op_e'(op_code);
            age     <= 3'd1;
        end else if (busy) begin
            age     <= age + 3'd1;
        end
    end

    // R1 R2 R3 R4 R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (age == op_latency(op_seen)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !busy) |=> (acc_hi == '0 && acc_lo == '0));

    // R1
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_seen == OP_MUL_N) |=> $stable(acc_hi));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && acc_hi == '0 && acc_lo == '0));

endmodule

bind seq_mac seq_mac_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_code (op_code),
    .clear   (clear),
    .busy    (busy),
    .done    (done),
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo)
);

// File: tb/seq_mac_test.sv
// Directed bench for seq_mac: one task per scenario, each checking itself.
module seq_mac_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        sgn_mode = 1'b0;
    logic        clear = 1'b0;
    logic        busy, done;
    logic [31:0] acc_hi, acc_lo;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] acc_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_mac uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sgn_mode(sgn_mode), .clear(clear),
        .busy(busy), .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Product from the requirements: narrow codes use bits 15:0.
    function automatic logic [63:0] model(logic [1:0] o, logic [31:0] x, logic [31:0] y, logic s);
        logic [63:0] ex, ey;
        if (o[1]) begin
            ex = s ? {{32{x[31]}}, x} : {32'b0, x};
            ey = s ? {{32{y[31]}}, y} : {32'b0, y};
        end else begin
            ex = s ? {{48{x[15]}}, x[15:0]} : {48'b0, x[15:0]};
            ey = s ? {{48{y[15]}}, y[15:0]} : {48'b0, y[15:0]};
        end
        return ex * ey;
    endfunction

    function automatic int exp_lat(logic [1:0] o);
        case (o)
            2'd0: return 2;
            2'd1: return 3;
            2'd2: return 3;
            default: return 4;
        endcase
    endfunction

    // Entered at a negedge; returns at the negedge where done is seen.
    task automatic run_op(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                          input logic s, input bit inject, input bit hold_clr, input string tag);
        logic [63:0] p, e;
        int lat;
        p = model(o, x, y, s);
        case (o)
            2'd0: e = {acc_m[63:32], p[31:0]};
            2'd2: e = p;
            default: e = acc_m + p;
        endcase
        op_code = o; opnd_a = x; opnd_b = y; sgn_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 1;
        chk(busy == 1'b1 && done == 1'b0, {tag, " R6 busy after start"}, {62'b0, busy, done}, 64'h2);
        if (inject) begin
            start = 1'b1; op_code = ~o; opnd_a = ~x; opnd_b = y + 32'd3; sgn_mode = ~s;
        end
        if (hold_clr) clear = 1'b1;
        while (!done && lat < 20) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        clear = 1'b0;
        chk(lat == exp_lat(o), {tag, " latency"}, 64'(lat), 64'(exp_lat(o)));
        chk(busy == 1'b0, {tag, " R6 busy low at done"}, {63'b0, busy}, 64'h0);
        chk({acc_hi, acc_lo} == e, {tag, " accumulator"}, {acc_hi, acc_lo}, e);
        acc_m = e;
    endtask

    task automatic idle_gap(input string tag);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R6 done one cycle"}, {63'b0, done}, 64'h0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9 control idle", {62'b0, busy, done}, 64'h0);
        chk({acc_hi, acc_lo} == 64'h0, "R9 accumulator zero", {acc_hi, acc_lo}, 64'h0);
        acc_m = '0;
    endtask

    task automatic t_mul_wide;
        run_op(2'd2, 32'h8000_0000, 32'h8000_0000, 1'b1, 0, 0, "R3 R5 signed min squared");
        idle_gap("R3");
        run_op(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, 0, "R3 R5 unsigned max squared");
        idle_gap("R3");
        run_op(2'd2, 32'hFFFF_FFFF, 32'h0001_2345, 1'b1, 0, 0, "R3 R5 minus one times positive");
        idle_gap("R3");
    endtask

    task automatic t_mul_narrow;
        run_op(2'd2, 32'h1234_5678, 32'h0000_0100, 1'b0, 0, 0, "R3 preload high half");
        idle_gap("R3");
        run_op(2'd0, 32'hABCD_FFFE, 32'h5555_0003, 1'b1, 0, 0, "R1 R5 signed narrow, high half kept");
        idle_gap("R1");
        run_op(2'd0, 32'h7777_FFFF, 32'h9999_FFFF, 1'b0, 0, 0, "R1 R5 unsigned narrow max");
        idle_gap("R1");
    endtask

    task automatic t_mac;
        run_op(2'd1, 32'h0000_8000, 32'h0000_7FFF, 1'b1, 0, 0, "R2 R5 negative narrow product extended");
        idle_gap("R2");
        run_op(2'd1, 32'hFFFF_FFFF, 32'h1111_FFFF, 1'b0, 0, 0, "R2 unsigned narrow accumulate");
        idle_gap("R2");
        run_op(2'd3, 32'h8000_0001, 32'h7FFF_FFFF, 1'b1, 0, 0, "R4 R5 signed wide accumulate");
        idle_gap("R4");
        run_op(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, 0, "R4 unsigned wide accumulate wraps");
        idle_gap("R4");
    endtask

    task automatic t_busy_start;
        run_op(2'd0, 32'h0000_0005, 32'h0000_0007, 1'b0, 1, 0, "R7 start ignored in narrow multiply");
        idle_gap("R7");
        run_op(2'd3, 32'h0001_0001, 32'hFFFF_0002, 1'b1, 1, 0, "R7 start ignored in wide accumulate");
        idle_gap("R7");
    endtask

    task automatic t_clear;
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk({acc_hi, acc_lo} == 64'h0, "R8 idle clear", {acc_hi, acc_lo}, 64'h0);
        acc_m = '0;
        run_op(2'd2, 32'h0000_1000, 32'h0010_0000, 1'b0, 0, 0, "R8 load before held clear");
        idle_gap("R8");
        run_op(2'd3, 32'h0000_0003, 32'h0000_0004, 1'b0, 0, 1, "R8 clear ignored while busy");
        idle_gap("R8");
    endtask

    task automatic t_back_to_back;
        run_op(2'd2, 32'h0000_0010, 32'h0000_0020, 1'b0, 0, 0, "R6 first of chain");
        run_op(2'd1, 32'h0000_0002, 32'h0000_0003, 1'b0, 0, 0, "R6 start in done cycle accepted");
        run_op(2'd0, 32'h0000_FFFF, 32'h0000_0002, 1'b1, 0, 0, "R6 third of chain");
        idle_gap("R6");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mul_wide();
        t_mul_narrow();
        t_mac();
        t_busy_start();
        t_clear();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule